// File: doc/BRIEF.md
# Dual Reloading Down-Counter Timers

This block holds a pair of down-counting timers that share one clock prescaler. The prescaler counts down from a fixed divisor. Each time it passes below zero it issues one step event and starts again from the divisor. On each step event both timers act together. A timer with a non-zero count decrements by one. A timer that already shows zero loads the value of its own reload register and pulses its own interrupt request. A timer therefore stays at zero for one whole step period before it wraps.

Software sets the reload values through a small write port. The write port addresses one timer at a time. A new reload value does not disturb the running count; it is used at that timer's next wrap. A combinational read port returns the full live count of the selected timer in one access. The asynchronous active-low reset is released synchronously inside the block. Reset leaves every count and every reload register at all ones.

Top module: `dual_tick_timer`

## Requirements
- R1: After reset both live counts and both reload registers hold all ones (0xFFFF at the default 16-bit width), and both interrupt bits are low.
- R2: The prescaler issues one step event every PRE_DIV+1 clock cycles (33 at the default divisor of 32), and both timers act on the same event.
- R3: On a step event a timer whose count is non-zero decrements by exactly one.
- R4: A timer whose count is zero keeps it for one full step period; on the next step event it loads its reload value.
- R5: irq is one bit per timer, bit 0 for timer 0 and bit 1 for timer 1. A bit is high for exactly one clock, in the cycle where the live count first shows the reloaded value, when PRE_DIV is at least 1.
- R6: A reload write (wr_en high, wr_idx picking the timer) leaves the live count unchanged and takes effect at that timer's next wrap.
- R7: rd_data shows the whole live count of the timer picked by rd_idx, in the same cycle that rd_idx is applied.
- R8: The timers are independent. A write to one timer's reload register does not affect the other timer. Each timer wraps with its own period of (reload+1)*(PRE_DIV+1) cycles.
- R9: With a reload value of zero, a timer stays at zero and raises its interrupt on every step event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_en | input | 1 | Write strobe for a reload register |
| wr_idx | input | IDX_W | Timer selected by the write |
| wr_data | input | CNT_W | New reload value |
| rd_idx | input | IDX_W | Timer whose live count is shown on rd_data |
| rd_data | output | CNT_W | Live count of the selected timer |
| irq | output | NUM_TMR | One-cycle interrupt pulse per timer, bit 0 for timer 0 |

## Verification
The hardest case to reach from the ports is the first wrap out of reset. It only comes after the full all-ones count has drained. At the default width and divisor that is over two million cycles. The bench therefore builds its main instance with an 8-bit count and a divisor of 4. The first wrap then comes after 1280 cycles, and the bench uses it to see the untouched all-ones reload value and the delayed effect of a reload write. A second instance at default parameters confirms the 16-bit reset value and the 33-cycle step period.

// File: rtl/dtt_pkg.sv
package dtt_pkg;
  localparam int unsigned DEF_CNT_W   = 16;
  localparam int unsigned DEF_NUM_TMR = 2;
  localparam int unsigned DEF_PRE_DIV = 32;

  // bits needed to index n items, never less than one
  function automatic int unsigned idx_w(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/dtt_prescaler.sv
module dtt_prescaler #(
  parameter int unsigned PRE_DIV = 32,
  parameter int unsigned PRE_W   = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic             tick,
  output logic [PRE_W-1:0] pre_val
);
  localparam logic [PRE_W-1:0] PRE_LD = PRE_W'(PRE_DIV);

  logic [PRE_W-1:0] pre_q, pre_d;

  always_comb begin
    tick  = (pre_q == '0);
    pre_d = tick ? PRE_LD : pre_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= PRE_LD;
    else        pre_q <= pre_d;
  end

  assign pre_val = pre_q;
endmodule

// File: rtl/dtt_counter.sv
module dtt_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             ld_en,
  input  logic [CNT_W-1:0] ld_val,
  output logic [CNT_W-1:0] cnt,
  output logic             irq
);
  logic [CNT_W-1:0] rld_q, rld_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             irq_q, irq_d;
  logic             at_zero;

  always_comb begin
    at_zero = (cnt_q == '0);
    rld_d   = ld_en ? ld_val : rld_q;
    cnt_d   = cnt_q;
    irq_d   = 1'b0;
    if (tick) begin
      if (at_zero) begin
        cnt_d = rld_q;
        irq_d = 1'b1;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rld_q <= '1;
      cnt_q <= '1;
      irq_q <= 1'b0;
    end else begin
      rld_q <= rld_d;
      cnt_q <= cnt_d;
      irq_q <= irq_d;
    end
  end

  assign cnt = cnt_q;
  assign irq = irq_q;
endmodule

// File: rtl/dual_tick_timer.sv
module dual_tick_timer
  import dtt_pkg::*;
#(
  parameter int unsigned CNT_W   = DEF_CNT_W,
  parameter int unsigned NUM_TMR = DEF_NUM_TMR,
  parameter int unsigned PRE_DIV = DEF_PRE_DIV,
  parameter int unsigned IDX_W   = idx_w(NUM_TMR)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [CNT_W-1:0]   wr_data,
  input  logic [IDX_W-1:0]   rd_idx,
  output logic [CNT_W-1:0]   rd_data,
  output logic [NUM_TMR-1:0] irq
);
  localparam int unsigned PRE_W = idx_w(PRE_DIV + 1);

  logic rst_meta, rst_ns;
  logic tick;
  logic [PRE_W-1:0] pre_val;
  logic [NUM_TMR-1:0][CNT_W-1:0] cnt_all;
  logic [NUM_TMR-1:0] ld_en;

  // reset asserts at once, releases on the second clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_ns   <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_ns   <= rst_meta;
    end
  end

  dtt_prescaler #(.PRE_DIV(PRE_DIV), .PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_ns), .tick(tick), .pre_val(pre_val)
  );

  for (genvar g = 0; g < NUM_TMR; g++) begin : g_tmr
    always_comb ld_en[g] = wr_en && (wr_idx == IDX_W'(g));

    dtt_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_ns), .tick(tick),
      .ld_en(ld_en[g]), .ld_val(wr_data),
      .cnt(cnt_all[g]), .irq(irq[g])
    );
  end

  always_comb rd_data = cnt_all[rd_idx];
endmodule

// File: rtl/dtt_checker.sv
module dtt_checker #(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned NUM_TMR = 2,
  parameter int unsigned PRE_DIV = 32,
  parameter int unsigned PRE_W   = 6
) (
  input logic                          clk,
  input logic                          rst_ns,
  input logic                          tick,
  input logic [PRE_W-1:0]              pre_val,
  input logic [NUM_TMR-1:0][CNT_W-1:0] cnt_all,
  input logic [NUM_TMR-1:0]            irq
);
  p_pre_bound_r2: assert property (@(posedge clk) disable iff (!rst_ns)
    pre_val <= PRE_W'(PRE_DIV));

  p_pre_restart_r2: assert property (@(posedge clk) disable iff (!rst_ns)
    tick |=> pre_val == PRE_W'(PRE_DIV));

  for (genvar g = 0; g < NUM_TMR; g++) begin : g_chk
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_ns)
      !tick |=> $stable(cnt_all[g]) && !irq[g]);

    p_dec_r3: assert property (@(posedge clk) disable iff (!rst_ns)
      tick && cnt_all[g] != '0 |=> cnt_all[g] == $past(cnt_all[g]) - CNT_W'(1) && !irq[g]);

    p_wrap_irq_r4: assert property (@(posedge clk) disable iff (!rst_ns)
      tick && cnt_all[g] == '0 |=> irq[g]);

    if (PRE_DIV > 0) begin : g_pulse
      p_irq_pulse_r5: assert property (@(posedge clk) disable iff (!rst_ns)
        irq[g] |=> !irq[g]);
    end
  end
endmodule

bind dual_tick_timer dtt_checker #(
  .CNT_W(CNT_W), .NUM_TMR(NUM_TMR), .PRE_DIV(PRE_DIV), .PRE_W(PRE_W)
) u_chk (
  .clk(clk), .rst_ns(rst_ns), .tick(tick), .pre_val(pre_val),
  .cnt_all(cnt_all), .irq(irq)
);

// File: tb/tb_dual_tick_timer.sv
module tb_dual_tick_timer;
  localparam int CLK_P = 10;
  localparam int W     = 8;
  localparam int DIV   = 4;
  localparam int TP    = DIV + 1;

  logic clk = 1'b0;
  logic rst_n;
  logic wr_en;
  logic wr_idx;
  logic [W-1:0] wr_data;
  logic rd_idx;
  logic [W-1:0] rd_data;
  logic [1:0] irq;
  logic [15:0] full_rd;
  logic [1:0] full_irq;

  int checks = 0;
  int errors = 0;

  always #(CLK_P/2) clk = ~clk;

  dual_tick_timer #(.CNT_W(W), .NUM_TMR(2), .PRE_DIV(DIV)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .rd_idx(rd_idx), .rd_data(rd_data), .irq(irq)
  );

  dual_tick_timer dut_full (
    .clk(clk), .rst_n(rst_n), .wr_en(1'b0), .wr_idx(1'b0),
    .wr_data(16'h0), .rd_idx(1'b0), .rd_data(full_rd), .irq(full_irq)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic rd(input logic idx, output logic [W-1:0] v);
    rd_idx = idx;
    #1;
    v = rd_data;
  endtask

  task automatic write_rld(input logic idx, input logic [W-1:0] v);
    wr_en = 1'b1; wr_idx = idx; wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // waits for irq bit b; returns cycles waited (negedges)
  task automatic wait_irq(input int b, input int lim, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!irq[b] && n < lim);
  endtask

  task automatic t_reset;
    logic [W-1:0] a, b;
    rd(1'b0, a); rd(1'b1, b);
    check(a == 8'hFF, "R1 timer0 count after reset", a, 255);
    check(b == 8'hFF, "R1 timer1 count after reset", b, 255);
    check(irq == 2'b00, "R1 irq after reset", irq, 0);
    check(full_rd == 16'hFFFF, "R1 default-width count after reset", full_rd, 65535);
  endtask

  task automatic t_period;
    logic [15:0] v;
    int n;
    n = 0;
    while (full_rd == 16'hFFFF && n < 100) begin @(negedge clk); n++; end
    v = full_rd; n = 0;
    while (full_rd == v && n < 100) begin @(negedge clk); n++; end
    check(n == 33, "R2 default step period", n, 33);
    check(full_rd == 16'hFFFD, "R3 default-width second decrement", full_rd, 65533);
  endtask

  task automatic t_decrement;
    logic [W-1:0] a, b, a2;
    int n;
    rd(1'b0, a); n = 0;
    do begin @(negedge clk); n++; rd(1'b0, a2); end while (a2 == a && n < 20);
    check(a2 == a - 8'd1, "R3 decrement by one", a2, a - 1);
    rd(1'b1, b);
    check(b == a2, "R2 both timers step on same event", b, a2);
  endtask

  task automatic t_first_wrap;
    logic [W-1:0] a, b;
    int n;
    write_rld(1'b0, 8'd5);
    rd(1'b0, a); rd(1'b1, b);
    check(a == b && a > 8'd9, "R6 reload write leaves live count", a, b);
    n = 0;
    do begin @(negedge clk); n++; rd(1'b0, a); end while (a != 0 && n < 2000);
    n = 0;
    do begin @(negedge clk); n++; rd(1'b0, a); end while (a == 0 && n < 20);
    check(n == TP, "R4 zero held one step period", n, TP);
    check(a == 8'd5, "R6 new reload used at wrap", a, 5);
    rd(1'b1, b);
    check(b == 8'hFF, "R1 reset reload value all ones", b, 255);
    check(irq == 2'b11, "R5 both irq bits at simultaneous wrap", irq, 3);
    @(negedge clk);
    check(irq == 2'b00, "R5 irq lasts one cycle", irq, 0);
  endtask

  task automatic t_independent;
    logic [W-1:0] a, b;
    int n;
    wait_irq(0, 200, n);
    check(n == 6*TP - 1, "R8 timer0 wrap period", n, 6*TP - 1);
    check(irq == 2'b01, "R5 only timer0 irq bit", irq, 1);
    rd(1'b0, a); rd(1'b1, b);
    check(a == 8'd5, "R7 read timer0 live count", a, 5);
    check(b == 8'hF9, "R8 timer1 unaffected by timer0", b, 249);
  endtask

  task automatic t_zero_reload;
    logic [W-1:0] a, b;
    int n;
    @(negedge clk);
    write_rld(1'b1, 8'd9);
    write_rld(1'b0, 8'd0);
    wait_irq(0, 200, n);
    rd(1'b0, a);
    check(a == 8'd0, "R9 zero reload loaded", a, 0);
    wait_irq(0, 200, n);
    check(n == TP, "R9 irq every step with zero reload", n, TP);
    rd(1'b0, a);
    check(a == 8'd0, "R9 count stays zero", a, 0);
    wait_irq(1, 2000, n);
    rd(1'b1, b);
    check(b == 8'd9, "R6 timer1 takes new reload at its own wrap", b, 9);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_idx = 1'b0; wr_data = '0; rd_idx = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_period();
    t_decrement();
    t_first_wrap();
    t_independent();
    t_zero_reload();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule